// File: doc/BRIEF.md
# Keyed Two-Stage Control Register

This block holds one control setting for the rest of the chip behind a two-step update. Software first writes a candidate value into a staging register. The value does not take effect until software writes a fixed key byte to a separate commit address. At that point the staged value is copied into the active setting, which drives the output bus. A commit byte other than the key is reserved, and writing it changes nothing. Because of this, a stray or partial write sequence cannot change the live setting.

The slave port is a plain synchronous register port. A write completes on a single clock edge when the write enable is high. Read data is a combinational function of the address and the current register contents. There are three mapped addresses:

- The staging register, which can be read and written.
- The commit address, which is write-only and reads as zero.
- The active readback address, which is read-only and shows the live setting separately from the staged one.

Top module: `keyed_ctrl_reg`

## Requirements
- R1: After reset, the staging register and the active setting both hold RESET_VAL (default 0x5A). The output bus and the readbacks at address 0 (staging) and address 2 (active) show that value.
- R2: A write to address 0 stores the write data in the staging register from the next clock edge on. The active setting does not change.
- R3: A write of the key byte 0xD5 to address 1 (commit) loads the active setting from the staging register at that clock edge. The output bus and the address 2 readback show the new value after the edge.
- R4: A write to address 1 of any value other than 0xD5 leaves the active setting unchanged.
- R5: A read at address 1 returns 0x00.
- R6: A read at address 2 returns the active setting, which is the same value as the output bus.
- R7: A write to address 2 or to the unmapped address 3 changes neither the staging register nor the active setting. A read at address 3 returns 0x00.
- R8: A commit copies the staging value held at the time of the commit. A staging write made after the commit does not change the active setting until the next key commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all register updates happen on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW (2) | Register address: 0 staging, 1 commit, 2 active readback |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Read data for bus_addr, combinational |
| active_out | output | DW (8) | Active setting driven to the rest of the chip |

## Verification
The assertions assume that the address, write enable and write data are settled before each rising edge and stay constant through it. They also assume that reset is only released while no write is pending. The bench meets these assumptions by changing every bus input only on the falling clock edge. It holds the write enable low during reset and releases reset on a falling edge. Non-key commit values include the bytes on either side of the key, zero and all ones. This makes the near-miss values visible as unchanged active readbacks.

// File: rtl/keyed_ctrl_reg.sv
module keyed_ctrl_reg #(
  parameter int              DW        = 8,
  parameter int              AW        = 2,
  parameter logic [DW-1:0]   RESET_VAL = 8'h5A,
  parameter logic [DW-1:0]   KEY       = 8'hD5,
  parameter logic [AW-1:0]   A_STAGE   = 2'd0,
  parameter logic [AW-1:0]   A_COMMIT  = 2'd1,
  parameter logic [AW-1:0]   A_ACTIVE  = 2'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] active_out
);

  logic [DW-1:0] stage_q;
  logic [DW-1:0] active_q;

  wire stage_wr = bus_we && (bus_addr == A_STAGE);
  wire key_hit  = bus_we && (bus_addr == A_COMMIT) && (bus_wdata == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= RESET_VAL;
    end else if (stage_wr) begin
      stage_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= RESET_VAL;
    end else if (key_hit) begin
      active_q <= stage_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAGE)       bus_rdata = stage_q;
    else if (bus_addr == A_ACTIVE) bus_rdata = active_q;
  end

  assign active_out = active_q;

  p_stage_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_STAGE) |=> (stage_q == $past(bus_wdata)));

  p_commit_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_COMMIT && bus_wdata == KEY) |=> (active_out == $past(stage_q)));

  p_no_key_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_COMMIT && bus_wdata == KEY) |=> $stable(active_out));

  p_commit_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_COMMIT) |-> (bus_rdata == '0));

  p_active_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_ACTIVE) |-> (bus_rdata == active_out));

  p_other_addr_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != A_STAGE) |=> $stable(stage_q));

endmodule

// File: tb/sim_keyed_ctrl_reg.sv
module sim_keyed_ctrl_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] active_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_stage;
  logic [7:0] m_active;
  string      cur_tag = "R1";

  always #10 clk = ~clk;

  keyed_ctrl_reg u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .active_out(active_out)
  );

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_stage;
      2'd2:    return m_active;
      default: return 8'h00;
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (bus_rdata !== exp_rd(bus_addr)) begin
      errors++;
      $display("FAIL %s rdata addr=%0d actual=%02h expected=%02h", cur_tag, bus_addr, bus_rdata, exp_rd(bus_addr));
    end
    checks++;
    if (active_out !== m_active) begin
      errors++;
      $display("FAIL %s active_out actual=%02h expected=%02h", cur_tag, active_out, m_active);
    end
  endtask

  task automatic step(input string tag, input logic [1:0] a, input logic w, input logic [7:0] d);
    @(negedge clk);
    compare();
    cur_tag = tag;
    bus_addr = a; bus_we = w; bus_wdata = d;
    if (w) begin
      if (a == 2'd0) m_stage = d;
      else if (a == 2'd1 && d == 8'hD5) m_active = m_stage;
    end
  endtask

  initial begin
    m_stage = 8'h5A;
    m_active = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1", 2'd0, 1'b0, 8'h00);
    step("R1", 2'd2, 1'b0, 8'h00);
    step("R5", 2'd1, 1'b0, 8'h00);
    step("R2", 2'd0, 1'b1, 8'h11);
    step("R2", 2'd0, 1'b0, 8'h00);
    step("R2", 2'd2, 1'b0, 8'h00);
    step("R4", 2'd1, 1'b1, 8'h00);
    step("R4", 2'd1, 1'b1, 8'hD4);
    step("R4", 2'd1, 1'b1, 8'hD6);
    step("R4", 2'd1, 1'b1, 8'hFF);
    step("R4", 2'd1, 1'b1, 8'h55);
    step("R4", 2'd2, 1'b0, 8'h00);
    step("R3", 2'd1, 1'b1, 8'hD5);
    step("R6", 2'd2, 1'b0, 8'h00);
    step("R8", 2'd0, 1'b1, 8'h22);
    step("R8", 2'd2, 1'b0, 8'h00);
    step("R8", 2'd0, 1'b0, 8'h00);
    step("R7", 2'd2, 1'b1, 8'h99);
    step("R7", 2'd3, 1'b1, 8'h77);
    step("R7", 2'd3, 1'b0, 8'h00);
    step("R7", 2'd0, 1'b0, 8'h00);
    step("R7", 2'd2, 1'b0, 8'h00);
    step("R3", 2'd1, 1'b1, 8'hD5);
    step("R6", 2'd2, 1'b0, 8'h00);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 3);
      step("R2", 2'd0, 1'b1, v);
      step("R4", 2'd1, 1'b1, (i % 3 == 0) ? 8'hD5 : 8'(v ^ 8'h80));
      step("R6", 2'(i % 4), 1'b0, 8'h00);
    end
    step("R5", 2'd1, 1'b0, 8'h00);
    step("R6", 2'd2, 1'b0, 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule